// File: doc/BRIEF.md
# Tag-stripping cell transmitter to multi-PHY

This block sits on the transmit side between a narrow framed data-path input and a multi-PHY UTOPIA Level 2 transmit bus. Cells arrive as a stream of 4-bit or 8-bit units. A frame-start strobe marks the first unit of each cell. The block packs the units into bytes and keeps one whole cell in a local buffer. It reads the destination port from the first byte of the cell. It then drops a configurable number of routing-tag bytes from the front of the cell.

A cell whose port field is all ones is an in-band control cell. It goes out on a separate byte-wide control output and never reaches a PHY. Every other cell goes to a PHY with a cell-level handshake. The block puts the port number on the transmit address lines and waits until that PHY reports room for a cell. It then writes the whole cell in one unbroken burst, 8 or 16 bits per cycle. While a cell is waiting or being sent, the data-path input is stalled.

A frame marker that arrives before the current cell is complete discards the partial cell. The block flags this with a one-cycle error pulse, and the marked unit becomes the first unit of the next cell.

Top module: `tag_strip_tx`

## Requirements
- R1: With `cfg_nibble`=0, each accepted unit is one byte taken from `in_data[7:0]`. With `cfg_nibble`=1, only `in_data[3:0]` is used, and two accepted units form one byte: the first unit gives bits 7:4 and the second gives bits 3:0.
- R2: A cell begins only with a unit that has `in_frm`=1. Units accepted without `in_frm` while no cell is partly collected are ignored, and nothing appears on any output because of them.
- R3: The cell length is `cfg_cell_len` bytes, in the range 52 to 56. From the edge where the last byte is accepted until the cell has fully left the block, `in_ready` is 0.
- R4: The destination port is bits 4:0 of the first byte of the cell. This is taken before any tag bytes are removed.
- R5: The first `cfg_tag_len` bytes of the cell (0 to 4) are removed. The rest of the cell is sent in its original order.
- R6: A cell whose port is 31 is a control cell. It is sent on `ctl_data` one byte per cycle with `ctl_valid`=1, and `ctl_sop`=1 on the first byte only. The transmit bus stays idle for such a cell.
- R7: A PHY cell is polled with `tx_addr` equal to its port. The burst starts in the cycle after a clock edge at which `tx_clav`=1. While `tx_clav`=0 the block keeps waiting and `in_ready` stays 0.
- R8: During a burst, `tx_enb_n` is 0 for consecutive cycles and carries one word per cycle. `tx_soc`=1 on the first word only. `tx_enb_n` returns to 1 in the cycle after the last word.
- R9: With `cfg_wide`=0, each word carries one byte on bits 7:0, with bits 15:8 at zero. With `cfg_wide`=1, the earlier byte is on bits 15:8 and the next byte on bits 7:0. An odd final byte is sent with bits 7:0 at zero. `tx_data` is zero whenever `tx_enb_n`=1.
- R10: An accepted unit with `in_frm`=1 while a cell is partly collected (a byte or a nibble) drops that partial cell. In that cycle `abort_pulse`=1, and the marked unit starts a new cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_nibble | input | 1 | 1 selects 4-bit input units |
| cfg_wide | input | 1 | 1 selects the 16-bit transmit bus |
| cfg_tag_len | input | 3 | Tag bytes to remove, 0 to 4 |
| cfg_cell_len | input | 6 | Incoming cell length in bytes, 52 to 56 |
| in_data | input | 8 | Data-path input unit |
| in_frm | input | 1 | First unit of a cell |
| in_valid | input | 1 | Unit present |
| in_ready | output | 1 | Unit accepted at the next edge when valid |
| tx_addr | output | 5 | PHY port address |
| tx_clav | input | 1 | Addressed PHY has room for a cell |
| tx_enb_n | output | 1 | Transmit enable, active low |
| tx_soc | output | 1 | First word of a cell |
| tx_data | output | 16 | Transmit word |
| ctl_valid | output | 1 | Control byte valid |
| ctl_sop | output | 1 | First control byte |
| ctl_data | output | 8 | Control cell byte |
| abort_pulse | output | 1 | Partial cell discarded |

## Verification
The assertions assume that the configuration inputs change only while no cell is held or partly collected. They also assume that `tx_clav` reflects the PHY at the current `tx_addr`. The bench changes the configuration only after waiting for `in_ready`, with no unit in flight. It derives `tx_clav` from a per-port space table indexed by `tx_addr`, so the PHY answer always follows the address the block drives. Stall cases are created by clearing a port's entry for a while and then setting it again.

// File: rtl/tag_strip_tx.sv
module tag_strip_tx #(
  parameter int MAX_CELL = 56,
  parameter int PORT_W   = 5,
  parameter int TAG_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_nibble,
  input  logic                           cfg_wide,
  input  logic [TAG_W-1:0]               cfg_tag_len,
  input  logic [$clog2(MAX_CELL+1)-1:0]  cfg_cell_len,
  input  logic [7:0]                     in_data,
  input  logic                           in_frm,
  input  logic                           in_valid,
  output logic                           in_ready,
  output logic [PORT_W-1:0]              tx_addr,
  input  logic                           tx_clav,
  output logic                           tx_enb_n,
  output logic                           tx_soc,
  output logic [15:0]                    tx_data,
  output logic                           ctl_valid,
  output logic                           ctl_sop,
  output logic [7:0]                     ctl_data,
  output logic                           abort_pulse
);
  localparam int CW = $clog2(MAX_CELL+1);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);
  localparam logic [PORT_W-1:0] CTRL_PORT = '1;

  typedef enum logic [1:0] {S_COLL, S_POLL, S_SEND, S_CTRL} st_t;
  st_t state;

  logic [7:0]        mem_q [MAX_CELL];
  logic [CW-1:0]     cnt, rd;
  logic              half;
  logic [3:0]        hi;
  logic [PORT_W-1:0] port;

  logic take, partial, nib_load, byte_wr, wr_last, send_last;
  logic [CW-1:0] wr_idx, rd1, rd2, tag_ext;
  logic [7:0] byte_val, lo_byte;

  assign in_ready  = (state == S_COLL);
  assign take      = in_valid && in_ready;
  assign partial   = (cnt != '0) || half;
  assign abort_pulse = take && in_frm && partial;
  assign nib_load  = take && cfg_nibble && (in_frm || (!half && cnt != '0));
  assign byte_wr   = take && (cfg_nibble ? (half && !in_frm) : (in_frm || cnt != '0));
  assign wr_idx    = in_frm ? '0 : cnt;
  assign wr_last   = (wr_idx + ONE) == cfg_cell_len;
  assign byte_val  = cfg_nibble ? {hi, in_data[3:0]} : in_data;
  assign tag_ext   = CW'(cfg_tag_len);
  assign rd1       = rd + ONE;
  assign rd2       = rd + TWO;
  assign send_last = cfg_wide ? (rd2 >= cfg_cell_len) : (rd1 == cfg_cell_len);
  assign lo_byte   = (rd1 < cfg_cell_len) ? mem_q[rd1] : 8'h00;

  assign tx_addr   = port;
  assign tx_enb_n  = (state != S_SEND);
  assign tx_soc    = (state == S_SEND) && (rd == tag_ext);
  assign tx_data   = (state != S_SEND) ? 16'h0 :
                     cfg_wide ? {mem_q[rd], lo_byte} : {8'h00, mem_q[rd]};
  assign ctl_valid = (state == S_CTRL);
  assign ctl_sop   = (state == S_CTRL) && (rd == tag_ext);
  assign ctl_data  = (state == S_CTRL) ? mem_q[rd] : 8'h00;

  always_ff @(posedge clk)
    if (byte_wr) mem_q[wr_idx] <= byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_COLL;
      cnt   <= '0;
      rd    <= '0;
      half  <= 1'b0;
      hi    <= '0;
      port  <= '0;
    end else begin
      case (state)
        S_COLL: begin
          if (nib_load) begin
            hi   <= in_data[3:0];
            half <= 1'b1;
            if (in_frm) cnt <= '0;
          end
          if (byte_wr) begin
            half <= 1'b0;
            if (wr_idx == '0) port <= byte_val[PORT_W-1:0];
            if (wr_last) begin
              cnt   <= '0;
              rd    <= tag_ext;
              state <= (port == CTRL_PORT) ? S_CTRL : S_POLL;
            end else begin
              cnt <= wr_idx + ONE;
            end
          end
        end
        S_POLL: if (tx_clav) state <= S_SEND;
        S_SEND: begin
          rd <= cfg_wide ? rd2 : rd1;
          if (send_last) state <= S_COLL;
        end
        default: begin
          rd <= rd1;
          if (rd1 == cfg_cell_len) state <= S_COLL;
        end
      endcase
    end
  end

  a_r8_soc_opens_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enb_n) |-> tx_soc);
  a_r8_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |=> !tx_soc);
  a_r3_stall_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enb_n || ctl_valid) |-> !in_ready);
  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enb_n |-> ($stable(tx_addr) && tx_addr != CTRL_PORT));
  a_r7_wait_clav: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && !tx_clav) |=> (tx_enb_n && !in_ready));
  a_r10_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> (in_ready && tx_enb_n && !ctl_valid));
  a_r6_sop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sop |-> ctl_valid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enb_n |-> (tx_data == 16'h0));
endmodule

// File: tb/tag_strip_tx_bench.sv
module tag_strip_tx_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_nibble = 0, cfg_wide = 0;
  logic [2:0] cfg_tag_len = 0;
  logic [5:0] cfg_cell_len = 6'd53;
  logic [7:0] in_data = 0;
  logic in_frm = 0, in_valid = 0;
  logic in_ready, tx_enb_n, tx_soc, tx_clav, ctl_valid, ctl_sop, abort_pulse;
  logic [4:0] tx_addr;
  logic [15:0] tx_data;
  logic [7:0] ctl_data;
  logic [31:0] space = '1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;
  assign tx_clav = space[tx_addr];

  tag_strip_tx u_tag_strip_tx (
    .clk(clk), .rst_n(rst_n), .cfg_nibble(cfg_nibble), .cfg_wide(cfg_wide),
    .cfg_tag_len(cfg_tag_len), .cfg_cell_len(cfg_cell_len),
    .in_data(in_data), .in_frm(in_frm), .in_valid(in_valid), .in_ready(in_ready),
    .tx_addr(tx_addr), .tx_clav(tx_clav), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
    .tx_data(tx_data), .ctl_valid(ctl_valid), .ctl_sop(ctl_sop),
    .ctl_data(ctl_data), .abort_pulse(abort_pulse));

  // behavioural reference: 0 collect, 1 poll, 2 send, 3 control
  int m_phase = 0;
  logic [7:0] bq[$];
  logic [7:0] pl[$];
  bit npend = 0, first = 0;
  logic [3:0] nhi = 0;
  int m_port = 0;

  task automatic finish_if_full();
    if (bq.size() == int'(cfg_cell_len)) begin
      m_port = int'(bq[0][4:0]);
      pl.delete();
      for (int i = int'(cfg_tag_len); i < bq.size(); i++) pl.push_back(bq[i]);
      bq.delete();
      first = 1;
      m_phase = (m_port == 31) ? 3 : 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; bq.delete(); pl.delete(); npend = 0; first = 0; m_port = 0;
    end else begin
      case (m_phase)
        0: if (in_valid) begin
          if (cfg_nibble) begin
            if (in_frm) begin bq.delete(); npend = 1; nhi = in_data[3:0]; end
            else if (npend) begin bq.push_back({nhi, in_data[3:0]}); npend = 0; finish_if_full(); end
            else if (bq.size() > 0) begin nhi = in_data[3:0]; npend = 1; end
          end else begin
            if (in_frm) begin bq.delete(); bq.push_back(in_data); finish_if_full(); end
            else if (bq.size() > 0) begin bq.push_back(in_data); finish_if_full(); end
          end
        end
        1: if (space[m_port]) m_phase = 2;
        2: begin
          void'(pl.pop_front());
          if (cfg_wide && pl.size() > 0) void'(pl.pop_front());
          first = 0;
          if (pl.size() == 0) m_phase = 0;
        end
        default: begin
          void'(pl.pop_front());
          first = 0;
          if (pl.size() == 0) m_phase = 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [15:0] e_data;
      logic [7:0] e_ctl;
      e_data = 16'h0;
      e_ctl = 8'h0;
      if (m_phase == 2)
        e_data = cfg_wide ? {pl[0], (pl.size() > 1) ? pl[1] : 8'h00} : {8'h00, pl[0]};
      if (m_phase == 3) e_ctl = pl[0];
      chk("R3 in_ready", 16'(in_ready), 16'(m_phase == 0));
      chk("R8 tx_enb_n", 16'(tx_enb_n), 16'(m_phase != 2));
      chk("R8 tx_soc", 16'(tx_soc), 16'(m_phase == 2 && first));
      chk("R1 R2 R4 R5 R9 tx_data", tx_data, e_data);
      chk("R6 ctl_valid", 16'(ctl_valid), 16'(m_phase == 3));
      chk("R6 ctl_sop", 16'(ctl_sop), 16'(m_phase == 3 && first));
      chk("R6 ctl_data", 16'(ctl_data), 16'(e_ctl));
      chk("R10 abort_pulse", 16'(abort_pulse),
          16'(m_phase == 0 && in_valid && in_frm && (bq.size() > 0 || npend)));
      if (m_phase == 1 || m_phase == 2) chk("R4 R7 tx_addr", 16'(tx_addr), 16'(m_port));
    end
  end

  task automatic drive(input logic [7:0] d, input logic f);
    @(negedge clk);
    while (!in_ready) begin in_valid = 0; in_frm = 0; @(negedge clk); end
    in_valid = 1; in_data = d; in_frm = f;
  endtask

  task automatic stop_drive();
    @(negedge clk);
    in_valid = 0; in_frm = 0;
  endtask

  task automatic send_bytes(input int port, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (i == 0) b[4:0] = 5'(port);
      if (cfg_nibble) begin
        drive({4'($urandom), b[7:4]}, i == 0);
        drive({4'($urandom), b[3:0]}, 1'b0);
      end else begin
        drive(b, i == 0);
      end
    end
  endtask

  task automatic send_cell(input int port);
    send_bytes(port, int'(cfg_cell_len));
    stop_drive();
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input bit nib, input bit wide, input int tag, input int len);
    wait_idle();
    cfg_nibble = nib; cfg_wide = wide; cfg_tag_len = 3'(tag); cfg_cell_len = 6'(len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R3 reset in_ready", 16'(in_ready), 16'd1);
    chk("R8 reset tx_enb_n", 16'(tx_enb_n), 16'd1);
    chk("R6 reset ctl_valid", 16'(ctl_valid), 16'd0);
    rst_n = 1;
    set_cfg(0, 0, 1, 53); send_cell(3);                 // R1 R5 narrow
    set_cfg(0, 1, 4, 56); send_cell(7);                 // R5 tag 4, R9 wide
    set_cfg(0, 1, 0, 53); send_cell(12);                // R9 odd tail, R4 tag 0
    set_cfg(1, 0, 2, 52); send_cell(5);                 // R1 nibble mode
    set_cfg(1, 1, 3, 55); send_cell(30);                // R1 R9
    set_cfg(0, 0, 2, 54); send_cell(31);                // R6 control cell
    set_cfg(1, 0, 0, 52); send_cell(31);                // R6 nibble, no strip
    set_cfg(0, 0, 1, 53);
    for (int i = 0; i < 5; i++) drive(8'(i * 37), 1'b0); // R2 ignored units
    stop_drive(); send_cell(4);
    space[9] = 0;                                       // R7 stall
    fork begin repeat (150) @(negedge clk); space[9] = 1; end join_none
    send_cell(9); send_cell(3);
    set_cfg(0, 1, 1, 52);
    send_bytes(6, 20); send_cell(8);                    // R10 byte abort
    set_cfg(1, 1, 2, 56);
    send_bytes(10, 7);
    drive(8'h0A, 1'b1);                                 // R10 abort with pending nibble
    stop_drive(); send_cell(11);
    set_cfg(0, 0, 4, 56); send_cell(31); send_cell(2);  // R6 then R8 back-to-back
    wait_idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule